// File: doc/BRIEF.md
# Dual-Rail Word Completion Detector

This block is the receiving front end for an N-bit word sent on dual-rail wire pairs. Each bit has a true rail and a false rail. The block decodes every pair, watches for the moment the whole word has become valid, and watches for the moment the whole word has gone back to the spacer. A done output tells the consumer which of the two phases the channel is in. The consumer reads the decoded single-rail word while done is high. It then waits for done to fall before it expects the next word.

Completion comes from a binary tree of two-input consensus elements, not from a wide AND gate. Each element rises only when both of its inputs are high and falls only when both are low. In every other case it keeps its value. This gives done hysteresis: it does not drop when only some bits have left the word, and it does not rise when only some bits have arrived. Each consensus element is modelled as a register on a local clock. The tree therefore adds one clock edge of latency per level. There are L = max(1, ceil(log2 WIDTH)) levels.

A sticky flag reports any pair that ever shows both rails high. Such a pair is never loaded into the decoded word.

Top module: `dr_completion_detector`

## Requirements
- R1: Pair encoding per bit: true=1,false=0 decodes as logic 1; true=0,false=1 decodes as logic 0; both low is the spacer (no data); both high is illegal. Bit i of `word_out` carries the decoded bit i.
- R2: While `rst_n` is low, and right after it is released, `done`, `bad_code` and every bit of `word_out` are 0.
- R3: Once every pair holds a valid code (either rail high), `done` goes high exactly L clock edges later, whatever order the bits arrived in.
- R4: After `done` has risen, `done` stays high while at least one pair is still valid, even after other pairs return to the spacer.
- R5: Once every pair is back at the spacer, `done` goes low exactly L clock edges later.
- R6: After `done` has fallen, `done` stays low while at least one pair is still at the spacer.
- R7: `word_out` changes only on the clock edge where `done` rises. It holds its value while `done` is high and through the following spacer phase.
- R8: `bad_code` goes high on the clock edge after any pair is sampled with both rails high. It stays high until reset.
- R9: If any pair shows both rails high on the edge where `done` rises, `word_out` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that updates the consensus elements |
| rst_n | input | 1 | Asynchronous active-low reset |
| rail_t | input | WIDTH | True rail of each pair |
| rail_f | input | WIDTH | False rail of each pair |
| word_out | output | WIDTH | Decoded word, captured when done rises |
| done | output | 1 | High from word completion until full return to spacer |
| bad_code | output | 1 | Sticky flag for any pair with both rails high |

## Verification
The bench makes bits arrive and leave one random subset at a time. It checks that done stays put until the last pair changes. A design that used plain AND logic would drop done during a partial return, and a tree that did not hold state would do the same. The bench counts the exact edge on which done moves, so a missing or extra tree level shows up as a latency error. It also changes the rails while done is high and injects an illegal pair at the moment of completion. A design that loaded the word on every cycle, or that loaded an illegal pair, would show a changed word.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // Number of registered tree levels for a word of w bits.
  function automatic int tree_levels(input int w);
    int lv;
    lv = 1;
    while ((1 << lv) < w) lv++;
    return lv;
  endfunction

  // Consensus element next state: all-high sets, all-low clears, else hold.
  function automatic logic c_next(input logic a, input logic b, input logic q);
    return (a & b) | (q & (a | b));
  endfunction
endpackage

// File: rtl/dr_rail_decode.sv
module dr_rail_decode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic [WIDTH-1:0] bit_valid,
  output logic [WIDTH-1:0] bit_value,
  output logic [WIDTH-1:0] bit_illegal
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pair
    assign bit_valid[i]   = rail_t[i] | rail_f[i];
    assign bit_value[i]   = rail_t[i] & ~rail_f[i];
    assign bit_illegal[i] = rail_t[i] & rail_f[i];
  end
endmodule

// File: rtl/dr_celem.sv
module dr_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  output logic q,
  output logic q_nxt
);
  import dr_pkg::*;

  assign q_nxt = c_next(in_a, in_b, q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dr_ctree.sv
module dr_ctree #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] leaf,
  output logic             root,
  output logic             root_nxt
);
  import dr_pkg::*;

  localparam int LEVELS = tree_levels(WIDTH);
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int INNER  = LEAVES - 1;

  // Heap layout: node 0 is the root, children of n are 2n+1 and 2n+2.
  logic [NODES-1:0] node;
  logic [INNER-1:0] node_nxt;

  for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
    if (k < WIDTH) begin : g_real
      assign node[INNER + k] = leaf[k];
    end else begin : g_pad
      // Padding copies leaf 0 so it always agrees with a real input.
      assign node[INNER + k] = leaf[0];
    end
  end

  for (genvar n = 0; n < INNER; n++) begin : g_node
    dr_celem u_c (
      .clk   (clk),
      .rst_n (rst_n),
      .in_a  (node[2*n+1]),
      .in_b  (node[2*n+2]),
      .q     (node[n]),
      .q_nxt (node_nxt[n])
    );
  end

  assign root     = node[0];
  assign root_nxt = node_nxt[0];
endmodule

// File: rtl/dr_completion_detector.sv
module dr_completion_detector #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_t,
  input  logic [WIDTH-1:0] rail_f,
  output logic [WIDTH-1:0] word_out,
  output logic             done,
  output logic             bad_code
);
  logic [WIDTH-1:0] bit_valid;
  logic [WIDTH-1:0] bit_value;
  logic [WIDTH-1:0] bit_illegal;
  logic             root_nxt;
  logic             any_illegal;
  logic             rise_ev;
  logic             word_load;
  logic [WIDTH-1:0] word_q;
  logic             bad_q;

  dr_rail_decode #(.WIDTH(WIDTH)) u_dec (
    .rail_t      (rail_t),
    .rail_f      (rail_f),
    .bit_valid   (bit_valid),
    .bit_value   (bit_value),
    .bit_illegal (bit_illegal)
  );

  dr_ctree #(.WIDTH(WIDTH)) u_tree (
    .clk      (clk),
    .rst_n    (rst_n),
    .leaf     (bit_valid),
    .root     (done),
    .root_nxt (root_nxt)
  );

  assign any_illegal = |bit_illegal;
  assign rise_ev     = root_nxt & ~done;
  assign word_load   = rise_ev & ~any_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      bad_q  <= 1'b0;
    end else begin
      if (word_load) word_q <= bit_value;
      bad_q <= bad_q | any_illegal;
    end
  end

  assign word_out = word_q;
  assign bad_code = bad_q;
endmodule

// File: rtl/dr_completion_checker.sv
module dr_completion_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] rail_t,
  input logic [WIDTH-1:0] rail_f,
  input logic [WIDTH-1:0] word_out,
  input logic             done,
  input logic             bad_code
);
  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done)) |-> $stable(word_out)); // R7
  AST_WORD_MOVES_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> $rose(done)); // R7
  AST_NO_ILLEGAL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(word_out) |-> $past(~|(rail_t & rail_f))); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    bad_code |=> bad_code); // R8
  AST_FLAG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(rail_t & rail_f)) |=> bad_code); // R8
endmodule

bind dr_completion_detector dr_completion_checker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rail_t   (rail_t),
  .rail_f   (rail_f),
  .word_out (word_out),
  .done     (done),
  .bad_code (bad_code)
);

// File: tb/dr_completion_detector_tb.sv
module dr_completion_detector_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] rail_t = '0;
  logic [W-1:0] rail_f = '0;
  logic [W-1:0] word_out;
  logic         done;
  logic         bad_code;

  int checks = 0;
  int fails  = 0;
  int lat;
  logic [W-1:0] last_word;
  int unsigned seed = 32'd4711;

  always #5 clk = ~clk;

  dr_completion_detector #(.WIDTH(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .rail_t(rail_t), .rail_f(rail_f),
    .word_out(word_out), .done(done), .bad_code(bad_code)
  );

  // Tree depth restated: smallest d >= 1 with 2**d >= W.
  function automatic int depth_of(input int w);
    int d;
    int cap;
    d = 1; cap = 2;
    while (cap < w) begin d = d + 1; cap = cap * 2; end
    return d;
  endfunction

  function automatic logic [W-1:0] true_rail(input logic [W-1:0] data, input logic [W-1:0] present);
    return data & present;
  endfunction

  function automatic logic [W-1:0] false_rail(input logic [W-1:0] data, input logic [W-1:0] present);
    return ~data & present;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [W-1:0] data, input logic [W-1:0] present);
    rail_t = true_rail(data, present);
    rail_f = false_rail(data, present);
  endtask

  // Bits arrive in random subsets; done must stay low until the last, then rise after lat edges.
  task automatic send_word(input logic [W-1:0] data);
    logic [W-1:0] present;
    logic [W-1:0] pick;
    present = '0;
    while (present != '1) begin
      pick = W'($urandom()) & ~present;
      if (pick == '0) pick = ~present & (~(~present) + W'(1)) ;
      if (pick == '0) pick = ~present;
      present = present | pick;
      drive(data, present);
      if (present != '1) begin
        tick(1 + int'($urandom() % 3));
        check("R6 done low while bits missing", 32'(done), 32'd0);
      end
    end
    tick(lat - 1);
    check("R3 done not early", 32'(done), 32'd0);
    tick(1);
    check("R3 done after all valid", 32'(done), 32'd1);
    check("R1 decoded word", 32'(word_out), 32'(data));
    last_word = data;
  endtask

  // Bits leave in random subsets; done must hold high until the last leaves.
  task automatic drain_word(input logic [W-1:0] data);
    logic [W-1:0] present;
    logic [W-1:0] pick;
    present = '1;
    while (present != '0) begin
      pick = W'($urandom()) & present;
      if (pick == '0) pick = present & (~present + W'(1));
      present = present & ~pick;
      drive(data, present);
      if (present != '0) begin
        tick(1 + int'($urandom() % 3));
        check("R4 done held during partial spacer", 32'(done), 32'd1);
        check("R7 word held while done high", 32'(word_out), 32'(last_word));
      end
    end
    tick(lat - 1);
    check("R5 done not early low", 32'(done), 32'd1);
    tick(1);
    check("R5 done low after spacer", 32'(done), 32'd0);
    check("R7 word held in spacer phase", 32'(word_out), 32'(last_word));
  endtask

  initial begin
    void'($urandom(seed));
    lat = depth_of(W);
    tick(3);
    check("R2 reset done", 32'(done), 32'd0);
    check("R2 reset word", 32'(word_out), 32'd0);
    check("R2 reset flag", 32'(bad_code), 32'd0);
    rst_n = 1'b1;
    tick(2);
    check("R2 done after release", 32'(done), 32'd0);

    // Directed: whole word at once, all ones, all zeros.
    drive(8'hA5, '1);
    tick(lat - 1);
    check("R3 simultaneous arrival early", 32'(done), 32'd0);
    tick(1);
    check("R3 simultaneous arrival", 32'(done), 32'd1);
    check("R1 word A5", 32'(word_out), 32'hA5);
    last_word = 8'hA5;
    // Change rails while done high: must not reload.
    drive(8'h3C, '1);
    tick(3);
    check("R7 no reload while done high", 32'(word_out), 32'hA5);
    drive(8'hA5, '1);
    drain_word(8'hA5);
    tick(1);
    send_word(8'hFF);
    drain_word(8'hFF);
    send_word(8'h00);
    drain_word(8'h00);

    // Random words with random arrival and departure orders.
    for (int it = 0; it < 40; it++) begin
      logic [W-1:0] d;
      d = W'($urandom());
      send_word(d);
      drain_word(d);
      check("R8 flag clear under legal traffic", 32'(bad_code), 32'd0);
    end

    // Illegal pair at completion: done rises, word keeps old value, flag sets.
    rail_t = 8'h0F | 8'h04;
    rail_f = 8'hF0 | 8'h04;
    tick(1);
    check("R8 flag set after illegal pair", 32'(bad_code), 32'd1);
    tick(lat - 1);
    check("R3 illegal counts as valid", 32'(done), 32'd1);
    check("R9 no load with illegal pair", 32'(word_out), 32'(last_word));
    drive('0, '0);
    tick(lat + 2);
    check("R5 done low after spacer", 32'(done), 32'd0);
    check("R8 flag sticky", 32'(bad_code), 32'd1);
    rst_n = 1'b0;
    tick(2);
    check("R2 reset clears flag", 32'(bad_code), 32'd0);
    check("R2 reset clears word", 32'(word_out), 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule